// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This block takes one packed IEEE single-precision value and turns it into a 32-bit integer, either unsigned or two's-complement signed, as selected by an input. The rounding of any fractional part follows a 2-bit mode input, unless a truncate input is set, which forces rounding toward zero. Besides the integer, the block reports three flags: invalid (the result could not be represented or the input was a NaN that has no integer meaning), inexact (a fractional part was discarded), and input-denormal.

The conversion logic is purely combinational. A parameter adds one output register stage, which is enabled by default, so results appear one clock after the inputs. The datapath splits the significand into an integer part and a 32-bit remainder. It adds a mode-dependent increment to the remainder and uses the carry out to round. Saturation and clamping rules are applied last.

Top module: `f2i_conv`

## Requirements
- R1: With the output register enabled (default), reset clears the integer and all flags, and each result appears on the outputs one clock edge after its inputs are applied.
- R2: The rounding mode input encodes 00 = to nearest with ties to even, 01 = toward plus infinity, 10 = toward minus infinity, 11 = toward zero. An in-range finite input gives its correctly rounded integer value.
- R3: A NaN input (exponent field all ones, nonzero fraction) gives 0 with invalid in signed mode. In unsigned mode it is treated as positive and gives 0xFFFFFFFF with invalid.
- R4: A finite or infinite input with biased exponent of 159 or more saturates and raises invalid, with inexact clear. Unsigned mode gives 0xFFFFFFFF for a positive input and 0 for a negative one. Signed mode gives 0x7FFFFFFF for a positive input and 0x80000000 for a negative one.
- R5: In unsigned mode, a negative input whose rounded magnitude is nonzero gives 0 with invalid.
- R6: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive) or 0x80000000 (negative) is clamped to that limit and raises invalid, with inexact clear. Otherwise the magnitude is negated for a negative input.
- R7: When the truncate input is 1, rounding is toward zero whatever the mode input holds.
- R8: For biased exponents below 126, a nonzero input always raises inexact. The result is 1 when rounding toward plus with a positive input. When rounding toward minus with a negative input, it is 0xFFFFFFFF in signed mode, or 0 with invalid in unsigned mode. In every other case the result is 0.
- R9: A zero input of either sign gives 0 with no flag set in both modes.
- R10: An input with zero exponent field and nonzero fraction raises the input-denormal flag.
- R11: Inexact is raised exactly when discarded fraction bits are nonzero and no invalid clamp or saturation took place. The one exception is the unsigned negative case of R8, which raises both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 32 | Packed single-precision operand |
| to_signed | input | 1 | 1 = signed integer result, 0 = unsigned |
| rnd_mode | input | 2 | Rounding mode, encoded as in R2 |
| trunc | input | 1 | 1 = force rounding toward zero |
| int_out | output | 32 | Integer result |
| flg_invalid | output | 1 | Invalid operation flag |
| flg_inexact | output | 1 | Inexact result flag |
| flg_denorm | output | 1 | Denormal input flag |

## Verification
The bench sweeps every biased exponent against fraction patterns, both signs, all modes, truncation and both integer types. This sweep covers ties at several bit positions, where a wrong nearest-even increment rounds halfway cases away from zero. It also covers the 126 and 159 exponent boundaries, where an off-by-one shift gives results doubled or halved, or fails to saturate. The negative-to-unsigned and signed clamp cases are included, where a design would wrap instead of clamping, or raise inexact alongside invalid. The expected results come from exact integer arithmetic on the significand, so a design with a wrong increment sign for directed modes, or a dropped truncate override, shows up as an off-by-one in the integer.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  parameter int INT_W  = 32;
  localparam int FP_W    = EXP_W + FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_BIG = BIAS + INT_W;      // saturation threshold
  localparam int EXP_MIN = BIAS - 1;          // smallest exponent on the shift path
  localparam int SH_W    = $clog2(INT_W + 1);

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_UP   = 2'b01,
    RND_DOWN = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
    logic denorm;
  } flags_t;
endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0]  fp_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [INT_W-1:0] sig_o,
  output logic             nan_o,
  output logic             zero_o,
  output logic             denorm_o,
  output logic             big_o,
  output logic             tiny_o
);
  localparam int PAD = INT_W - FRAC_W - 2;

  logic [FRAC_W-1:0] frac_w;
  logic              frac_nz;
  logic              exp_nz;
  logic              exp_max;

  assign sign_o  = fp_i[FP_W-1];
  assign exp_o   = fp_i[FP_W-2:FRAC_W];
  assign frac_w  = fp_i[FRAC_W-1:0];
  assign frac_nz = |frac_w;
  assign exp_nz  = |exp_o;
  assign exp_max = &exp_o;

  // hidden bit sits one below the top of the integer-width significand
  assign sig_o    = {1'b0, exp_nz, frac_w, {PAD{1'b0}}};
  assign nan_o    = exp_max & frac_nz;
  assign zero_o   = ~exp_nz & ~frac_nz;
  assign denorm_o = ~exp_nz & frac_nz;
  assign big_o    = 32'(exp_o) >= EXP_BIG;
  assign tiny_o   = 32'(exp_o) < EXP_MIN;
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
(
  input  logic [INT_W-1:0] sig_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             sign_i,
  input  rnd_e             mode_i,
  output logic [INT_W-1:0] whole_o,
  output logic             rem_nz_o,
  output logic             carry_o
);
  localparam int TOP = EXP_BIG - 1;
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic [SH_W-1:0]    sh;
  logic [2*INT_W-1:0] wide;
  logic [INT_W-1:0]   rem;
  logic [INT_W-1:0]   incr;
  logic [INT_W-1:0]   sum;

  always_comb begin
    if (32'(exp_i) >= TOP)          sh = '0;
    else if (32'(exp_i) <= EXP_MIN) sh = SH_W'(INT_W);
    else                            sh = SH_W'(TOP - 32'(exp_i));
  end

  // upper half is the integer part, lower half the discarded fraction
  assign wide     = ({sig_i, {INT_W{1'b0}}} << 1) >> sh;
  assign whole_o  = wide[2*INT_W-1:INT_W];
  assign rem      = wide[INT_W-1:0];
  assign rem_nz_o = |rem;

  always_comb begin
    case (mode_i)
      RND_NEAR: incr = whole_o[0] ? HALF : HALF - 1'b1;
      RND_UP:   incr = sign_i ? '0 : '1;
      RND_DOWN: incr = sign_i ? '1 : '0;
      default:  incr = '0;
    endcase
  end

  assign {carry_o, sum} = {1'b0, rem} + {1'b0, incr};
endmodule

// File: rtl/f2i_select.sv
`timescale 1ns/1ps
module f2i_select
  import f2i_pkg::*;
(
  input  logic             signed_i,
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             zero_i,
  input  logic             denorm_i,
  input  logic             big_i,
  input  logic             tiny_i,
  input  rnd_e             mode_i,
  input  logic [INT_W-1:0] whole_i,
  input  logic             rem_nz_i,
  input  logic             carry_i,
  output logic [INT_W-1:0] res_o,
  output flags_t           flg_o
);
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE   = {{(INT_W-1){1'b0}}, 1'b1};

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] lim;

  // an unsigned NaN is handled as positive
  assign neg = sign_i & ~(nan_i & ~signed_i);
  assign lim = neg ? S_MIN : S_MAX;

  always_comb begin
    res_o         = '0;
    mag           = whole_i;
    flg_o.invalid = 1'b0;
    flg_o.inexact = 1'b0;
    flg_o.denorm  = denorm_i;
    if (signed_i && nan_i) begin
      flg_o.invalid = 1'b1;
    end else if (big_i) begin
      flg_o.invalid = 1'b1;
      if (signed_i) res_o = neg ? S_MIN : S_MAX;
      else          res_o = neg ? '0 : '1;
    end else if (!tiny_i) begin
      if (signed_i) begin
        if (carry_i && whole_i != '1) mag = whole_i + ONE;
        if (mag > lim) begin
          mag           = lim;
          flg_o.invalid = 1'b1;
        end else begin
          flg_o.inexact = rem_nz_i;
        end
        res_o = neg ? (~mag + ONE) : mag;
      end else begin
        if (carry_i) begin
          if (whole_i != '1) mag = whole_i + ONE;
          else               flg_o.invalid = 1'b1;
        end
        if (mag != '0 && neg) begin
          flg_o.invalid = 1'b1;
        end else begin
          res_o         = mag;
          flg_o.inexact = rem_nz_i;
        end
      end
    end else if (!zero_i) begin
      flg_o.inexact = 1'b1;
      if (mode_i == RND_UP && !neg) begin
        res_o = ONE;
      end else if (mode_i == RND_DOWN && neg) begin
        if (signed_i) res_o = '1;
        else          flg_o.invalid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/f2i_conv.sv
`timescale 1ns/1ps
module f2i_conv
  import f2i_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FP_W-1:0]  fp_in,
  input  logic             to_signed,
  input  logic [1:0]       rnd_mode,
  input  logic             trunc,
  output logic [INT_W-1:0] int_out,
  output logic             flg_invalid,
  output logic             flg_inexact,
  output logic             flg_denorm
);
  logic             sign_w, nan_w, zero_w, denorm_w, big_w, tiny_w;
  logic [EXP_W-1:0] exp_w;
  logic [INT_W-1:0] sig_w, whole_w;
  logic             rem_nz_w, carry_w;
  rnd_e             mode_eff;
  logic [INT_W-1:0] res_c;
  flags_t           flg_c;

  assign mode_eff = trunc ? RND_ZERO : rnd_e'(rnd_mode);

  f2i_unpack u_unpack (
    .fp_i     (fp_in),
    .sign_o   (sign_w),
    .exp_o    (exp_w),
    .sig_o    (sig_w),
    .nan_o    (nan_w),
    .zero_o   (zero_w),
    .denorm_o (denorm_w),
    .big_o    (big_w),
    .tiny_o   (tiny_w)
  );

  f2i_round u_round (
    .sig_i    (sig_w),
    .exp_i    (exp_w),
    .sign_i   (sign_w),
    .mode_i   (mode_eff),
    .whole_o  (whole_w),
    .rem_nz_o (rem_nz_w),
    .carry_o  (carry_w)
  );

  f2i_select u_select (
    .signed_i (to_signed),
    .sign_i   (sign_w),
    .nan_i    (nan_w),
    .zero_i   (zero_w),
    .denorm_i (denorm_w),
    .big_i    (big_w),
    .tiny_i   (tiny_w),
    .mode_i   (mode_eff),
    .whole_i  (whole_w),
    .rem_nz_i (rem_nz_w),
    .carry_i  (carry_w),
    .res_o    (res_c),
    .flg_o    (flg_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [INT_W-1:0] res_q;
      flags_t           flg_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          flg_q <= '0;
        end else begin
          res_q <= res_c;
          flg_q <= flg_c;
        end
      end

      assign int_out     = res_q;
      assign flg_invalid = flg_q.invalid;
      assign flg_inexact = flg_q.inexact;
      assign flg_denorm  = flg_q.denorm;

      AST_REG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int_out == $past(res_c) && flg_q == $past(flg_c))); // R1
    end else begin : g_comb
      assign int_out     = res_c;
      assign flg_invalid = flg_c.invalid;
      assign flg_inexact = flg_c.inexact;
      assign flg_denorm  = flg_c.denorm;
    end
  endgenerate

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    zero_w |-> (res_c == '0 && flg_c == '0)); // R9
  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (nan_w && to_signed) |-> (res_c == '0 && flg_c.invalid)); // R3
  AST_BIG_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    big_w |-> (flg_c.invalid && !flg_c.inexact)); // R4
  AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_signed && sign_w && !nan_w) |-> (res_c == '0)); // R5
  AST_DENORM_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    flg_c.denorm |-> (res_c == '0 || res_c == '1 || res_c == INT_W'(1))); // R10
endmodule

// File: tb/f2i_conv_test.sv
`timescale 1ns/1ps
module f2i_conv_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fp_in;
  logic        to_signed;
  logic [1:0]  rnd_mode;
  logic        trunc;
  logic [31:0] int_out;
  logic        flg_invalid, flg_inexact, flg_denorm;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  f2i_conv uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fp_in       (fp_in),
    .to_signed   (to_signed),
    .rnd_mode    (rnd_mode),
    .trunc       (trunc),
    .int_out     (int_out),
    .flg_invalid (flg_invalid),
    .flg_inexact (flg_inexact),
    .flg_denorm  (flg_denorm)
  );

  task automatic check(input string tag, input logic [31:0] exp_r,
                       input bit ei, input bit ex, input bit ed);
    checks++;
    if (int_out !== exp_r || flg_invalid !== ei || flg_inexact !== ex || flg_denorm !== ed) begin
      errors++;
      $display("FAIL %s: in=%h signed=%0d mode=%0d trunc=%0d got %h inv=%b inx=%b dn=%b expected %h inv=%b inx=%b dn=%b",
               tag, fp_in, to_signed, rnd_mode, trunc, int_out, flg_invalid, flg_inexact,
               flg_denorm, exp_r, ei, ex, ed);
    end
  endtask

  // exact-arithmetic reference
  task automatic model(input logic [31:0] f, input bit sgnd, input int md,
                       input bit tr, output logic [31:0] r, output bit inv,
                       output bit inx, output bit dn, output string tag);
    bit     s  = f[31];
    int     e  = int'(f[30:23]);
    longint fr = longint'(f[22:0]);
    longint m, ip, rr, half, mag, lim;
    int     ee, sh;
    bit     fnz, gt, eqh, up, tiny;
    r = '0; inv = 0; inx = 0;
    dn = (e == 0 && fr != 0);
    if (e == 255 && fr != 0) begin
      tag = "R3"; inv = 1; r = sgnd ? 32'h0 : 32'hffffffff; return;
    end
    if (e >= 159) begin
      tag = "R4"; inv = 1;
      if (sgnd) r = s ? 32'h80000000 : 32'h7fffffff;
      else      r = s ? 32'h0 : 32'hffffffff;
      return;
    end
    if (e == 0 && fr == 0) begin tag = "R9"; return; end
    ee = (e == 0) ? 1 : e;
    m  = (e == 0) ? fr : (fr | (64'd1 << 23));
    sh = 150 - ee;
    fnz = 0; gt = 0; eqh = 0;
    if (sh <= 0) ip = m << (-sh);
    else if (sh >= 40) begin ip = 0; fnz = 1; end
    else begin
      ip   = m >> sh;
      rr   = m & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      fnz  = rr != 0; gt = rr > half; eqh = rr == half;
    end
    case (md)
      0: up = gt || (eqh && ip[0]);
      1: up = fnz && !s;
      2: up = fnz && s;
      default: up = 0;
    endcase
    mag  = ip + longint'(up);
    tiny = ee < 126;
    if (sgnd) begin
      lim = s ? 64'h80000000 : 64'h7fffffff;
      if (mag > lim) begin mag = lim; inv = 1; end
      else inx = fnz;
      r = s ? 32'(-mag) : 32'(mag);
      tag = inv ? "R6" : "R2";
    end else begin
      if (s && mag != 0) begin inv = 1; inx = tiny; tag = "R5"; end
      else begin r = 32'(mag); inx = fnz; tag = "R2"; end
    end
    if (dn) tag = "R10";
    else if (tr) tag = "R7";
    else if (tiny) tag = "R8";
    else if (tag == "R2" && fnz) tag = "R11";
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [22:0] FRACS [8] = '{23'h000000, 23'h000001, 23'h400000, 23'h7fffff,
                                        23'h200001, 23'h3fffff, 23'h000080, 23'h155555};

  initial begin
    logic [31:0] er;
    bit ei, ex, ed;
    string tg;
    rst_n = 1'b0; fp_in = 32'h3f800000; to_signed = 1'b1; rnd_mode = 2'b00; trunc = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", 32'h0, 0, 0, 0);          // reset state
    @(negedge clk) rst_n = 1'b1;
    fp_in = 32'h40400000;                     // 3.0
    #1 check("R1", 32'h0, 0, 0, 0);          // not yet through the register
    @(posedge clk); #1 check("R1", 32'd3, 0, 0, 0);

    for (int sg = 0; sg < 2; sg++)
      for (int mi = 0; mi < 5; mi++)
        for (int e = 0; e < 256; e++)
          for (int fi = 0; fi < 8; fi++)
            for (int s = 0; s < 2; s++) begin
              @(negedge clk);
              fp_in     = {s[0], e[7:0], FRACS[fi]};
              to_signed = sg[0];
              trunc     = (mi == 4);
              rnd_mode  = (mi == 4) ? e[1:0] : mi[1:0];
              model(fp_in, sg[0], (mi == 4) ? 3 : mi, mi == 4, er, ei, ex, ed, tg);
              @(posedge clk); #1 check(tg, er, ei, ex, ed);
            end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule